// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Model

This block is a synthesizable behavioural model of a small synchronous burst SRAM. The read path has a single register stage. It is meant to sit in a testbench in place of an external memory. There are two active-low address strobes, one driven by a processor and one by a memory controller. Either strobe starts an access at the address presented. After that, an advance input walks a two-bit burst counter through four beats. A strap input picks the beat order: linear or interleaved. Writes are done one byte lane at a time. A lane holds eight data bits plus one parity bit. A global write input stores all four lanes at once.

The data bus is split into `wr_data`, `rd_data` and a drive flag `rd_drive`, so the model has no tristate net. The bus counts as floating when `rd_drive` is low, and `rd_data` then reads zero.

Control is a five-state machine:
- `ST_DESEL`: deselected.
- `ST_WAKE`: first read cycle after leaving the deselected or sleep state.
- `ST_READ`: read.
- `ST_WRITE`: write.
- `ST_SLEEP`: sleep.

The transitions are:
- Sleep high moves any state to `ST_SLEEP`.
- A strobe with the chip deselected moves any state to `ST_DESEL`.
- A selected strobe, or a cycle with no strobe while a burst is running, moves to `ST_WRITE` if a write is requested. Otherwise it moves to `ST_WAKE` when coming from `ST_DESEL` or `ST_SLEEP`, and to `ST_READ` from anywhere else.
- A cycle with no strobe moves `ST_SLEEP` to `ST_DESEL`, and keeps `ST_DESEL` where it is.

Top module: `fts_sram`

## Requirements
- R1: When `ctl_strobe_n` is low and `chip_sel_n` is low at a rising edge, the address on `addr` is captured. Its two low bits become the burst start, and the counter is reset to beat 0.
- R2: When both strobes are low at the same edge, only the processor strobe is acted on. The access is a read of `addr`, and no write takes place whatever the write inputs say.
- R3: The 36-bit word is made of four 9-bit lanes. Lane g occupies bits [9g+8:9g], and its parity bit is bit 9g+8. Lane g is written only when `bwe_n` is low and `byte_sel_n[g]` is low at the edge. With `bwe_n` high and `all_wr_n` high, nothing is written.
- R4: When `all_wr_n` is low at an edge, all four lanes are written, whatever `bwe_n` and `byte_sel_n` are.
- R5: In the cycle after an edge, `rd_data` holds the word at the address registered at that edge.
- R6: While `oe_n` is high, `rd_drive` is low and `rd_data` is zero.
- R7: In the cycle after a write edge, the bus floats.
- R8: In the first cycle after leaving `ST_DESEL` or `ST_SLEEP`, the bus floats even on a read.
- R9: A strobe with `chip_sel_n` high deselects the chip. The bus then floats until a selected strobe arrives. Advance and suspend cycles do not leave this state.
- R10: With `order_sel` low, beat k addresses low bits (start + k) mod 4.
- R11: With `order_sel` high, beat k addresses low bits start XOR k.
- R12: A cycle with `adv_n` low and no strobe steps the counter by one beat, and it returns to the start after four beats. A cycle with `adv_n` high and no strobe keeps the current address.
- R13: `sleep` high floats the bus at once, without waiting for a clock. Commands are ignored while it is high, including writes, and stored data is kept. Commands are accepted again at the first edge with `sleep` low.
- R14: After `rst_n` is released, the state is `ST_DESEL` and the bus floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| chip_sel_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address |
| order_sel | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low |
| bwe_n | input | 1 | Lane write enable, active low |
| byte_sel_n | input | LANES | Per-lane write selects, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Read data, zero while floating |
| rd_drive | output | 1 | High when the bus is driven |

## Verification
The bench uses the default parameters: a 6-bit address (64 words) and four 9-bit lanes. With only 64 words, one aligned group of four words can be filled and then read back in both orders. Two orders are exercised: a start of 2 in linear mode, which wraps past the group boundary, and a start of 1 in interleaved mode, which steps through the XOR pattern. The 9-bit lanes put each parity bit at a known position. A partial write can therefore be shown to flip a parity bit only in the selected lanes.

// File: rtl/fts_pkg.sv
package fts_pkg;

    typedef enum logic [2:0] {
        ST_DESEL,
        ST_WAKE,
        ST_READ,
        ST_WRITE,
        ST_SLEEP
    } fts_state_e;

    typedef enum logic [1:0] {
        ADR_KEEP,
        ADR_LOAD,
        ADR_STEP
    } fts_adr_op_e;

endpackage

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fts_adr_op_e       op,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);

    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_q, hi_d;
    logic [1:0]      start_q, start_d;
    logic [1:0]      cnt_q, cnt_d;

    // beat address: interleaved xors the count in, linear adds it
    function automatic logic [1:0] beat(input logic il, input logic [1:0] s, input logic [1:0] c);
        return il ? (s ^ c) : (s + c);
    endfunction

    always_comb begin
        hi_d    = hi_q;
        start_d = start_q;
        cnt_d   = cnt_q;
        unique case (op)
            ADR_LOAD: begin
                hi_d    = addr_in[ADDR_W-1:2];
                start_d = addr_in[1:0];
                cnt_d   = 2'd0;
            end
            ADR_STEP: cnt_d = cnt_q + 2'd1;
            ADR_KEEP: ;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= 2'd0;
            cnt_q   <= 2'd0;
        end else begin
            hi_q    <= hi_d;
            start_q <= start_d;
            cnt_q   <= cnt_d;
        end
    end

    assign cur_addr = {hi_q, beat(order_sel, start_q, cnt_q)};
    assign nxt_addr = {hi_d, beat(order_sel, start_d, cnt_d)};

    // R12: a step moves within the aligned group of four
    assert_step_moves_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADR_STEP) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))
                             && (cur_addr[1:0] != $past(cur_addr[1:0])));

    // R12: suspend holds the address while the strap is steady
    assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADR_KEEP) |=> ($stable(cur_addr) || !$stable(order_sel)));

    // R1: a load lands on the presented address
    assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ADR_LOAD) |=> (cur_addr == $past(addr_in)) || !$stable(order_sel));

endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
    import fts_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             cpu_n,
    input  logic             ctl_n,
    input  logic             sel_n,
    input  logic             adv_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] byte_sel_n,
    input  logic             all_wr_n,
    input  logic             oe_n,
    output fts_adr_op_e      adr_op,
    output logic [LANES-1:0] wr_be,
    output logic             out_en
);

    fts_state_e       state_q, state_d;
    logic [LANES-1:0] be_cmd;
    logic             idle;
    fts_state_e       rd_state;

    // lane enables requested by the write inputs
    always_comb begin
        if (!all_wr_n)
            be_cmd = '1;
        else if (!bwe_n)
            be_cmd = ~byte_sel_n;
        else
            be_cmd = '0;
    end

    assign idle     = (state_q == ST_DESEL) || (state_q == ST_SLEEP);
    assign rd_state = idle ? ST_WAKE : ST_READ;

    // command decode and next state
    always_comb begin
        state_d = state_q;
        adr_op  = ADR_KEEP;
        wr_be   = '0;
        if (sleep) begin
            state_d = ST_SLEEP;
        end else if (!cpu_n) begin
            if (sel_n) begin
                state_d = ST_DESEL;
            end else begin
                adr_op  = ADR_LOAD;
                state_d = rd_state;
            end
        end else if (!ctl_n) begin
            if (sel_n) begin
                state_d = ST_DESEL;
            end else begin
                adr_op = ADR_LOAD;
                if (|be_cmd) begin
                    wr_be   = be_cmd;
                    state_d = ST_WRITE;
                end else begin
                    state_d = rd_state;
                end
            end
        end else if (idle) begin
            state_d = ST_DESEL;
        end else begin
            if (!adv_n)
                adr_op = ADR_STEP;
            if (|be_cmd) begin
                wr_be   = be_cmd;
                state_d = ST_WRITE;
            end else begin
                state_d = ST_READ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_DESEL;
        else
            state_q <= state_d;
    end

    // bus drive: only a settled read with output enable, never in sleep
    always_comb begin
        out_en = 1'b0;
        unique case (state_q)
            ST_READ:  out_en = !oe_n && !sleep;
            ST_DESEL: out_en = 1'b0;
            ST_WAKE:  out_en = 1'b0;
            ST_WRITE: out_en = 1'b0;
            ST_SLEEP: out_en = 1'b0;
            default:  out_en = 1'b0;
        endcase
    end

    assert_proc_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !cpu_n && !ctl_n && !sel_n) |=> (state_q == ST_READ || state_q == ST_WAKE));

    assert_lane_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bwe_n && all_wr_n) |-> (wr_be == '0));

    assert_oe_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !out_en);

    assert_wake_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !sleep && state_d != ST_DESEL && state_d != ST_WRITE) |=> !out_en);

    assert_desel_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DESEL) |-> !out_en);

    assert_sleep_freeze_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (wr_be == '0) && (adr_op == ADR_KEEP));

endmodule

// File: rtl/fts_array.sv
module fts_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        wr_be,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_be[g])
                lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];

        // R3: an enabled lane holds the written value afterwards
        assert_lane_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_be[g] |=> (lane_mem[$past(wr_addr)] == $past(wr_data[g*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_strobe_n,
    input  logic                    ctl_strobe_n,
    input  logic                    chip_sel_n,
    input  logic                    adv_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    order_sel,
    input  logic                    oe_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        byte_sel_n,
    input  logic                    all_wr_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_drive
);

    localparam int DATA_W = LANES * LANE_W;

    fts_adr_op_e       adr_op;
    logic [LANES-1:0]  wr_be;
    logic              out_en;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic [DATA_W-1:0] arr_q;

    fts_ctrl #(.LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .cpu_n      (cpu_strobe_n),
        .ctl_n      (ctl_strobe_n),
        .sel_n      (chip_sel_n),
        .adv_n      (adv_n),
        .bwe_n      (bwe_n),
        .byte_sel_n (byte_sel_n),
        .all_wr_n   (all_wr_n),
        .oe_n       (oe_n),
        .adr_op     (adr_op),
        .wr_be      (wr_be),
        .out_en     (out_en)
    );

    fts_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (adr_op),
        .order_sel (order_sel),
        .addr_in   (addr),
        .cur_addr  (cur_addr),
        .nxt_addr  (nxt_addr)
    );

    fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_be   (wr_be),
        .wr_addr (nxt_addr),
        .wr_data (wr_data),
        .rd_addr (cur_addr),
        .rd_data (arr_q)
    );

    assign rd_drive = out_en;
    assign rd_data  = out_en ? arr_q : '0;

    assert_write_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_be) |=> !rd_drive);

    assert_sleep_float_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rd_drive);

    assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));

endmodule

// File: tb/fts_sram_bench.sv
module fts_sram_bench;

    localparam logic [35:0] D0 = 36'h111111111;
    localparam logic [35:0] D1 = 36'h222222222;
    localparam logic [35:0] D2 = 36'h333333333;
    localparam logic [35:0] D3 = 36'h444444444;
    localparam logic [35:0] DX = 36'hFFFFFFFFF;
    localparam logic [35:0] DA = 36'hAAAAAAAAA;
    localparam logic [35:0] D5 = 36'h555555555;

    typedef struct packed {
        logic        cpu_n;
        logic        ctl_n;
        logic        sel_n;
        logic        adv_n;
        logic        gw_n;
        logic [5:0]  a;
        logic [35:0] wd;
        logic        eoe;
        logic [35:0] ed;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'h10, D0,    1'b0, 36'h0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'h00, D1,    1'b0, 36'h0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'h00, D2,    1'b0, 36'h0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'h00, D3,    1'b0, 36'h0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'h12, 36'h0, 1'b1, D2},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'h00, 36'h0, 1'b1, D3},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'h00, 36'h0, 1'b1, D0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'h00, 36'h0, 1'b1, D1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'h00, 36'h0, 1'b1, D2},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'h00, 36'h0, 1'b1, D2},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'h11, DX,    1'b1, D1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'h11, 36'h0, 1'b1, D1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'h13, 36'h0, 1'b0, 36'h0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'h00, 36'h0, 1'b0, 36'h0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'h13, 36'h0, 1'b0, 36'h0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'h00, 36'h0, 1'b1, D0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2, 3: return "R7 R4 write burst floats";
            4:          return "R1 R5 strobe read";
            5, 6, 7:    return "R10 linear beat";
            8:          return "R12 wrap to start";
            9:          return "R12 suspend holds";
            10:         return "R2 processor strobe wins";
            11:         return "R2 no write happened";
            12:         return "R9 deselect floats";
            13:         return "R9 advance stays deselected";
            14:         return "R8 first cycle after deselect";
            default:    return "R10 R12 beat after wake";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_n, ctl_n, sel_n, adv_n, oe_n, bwe_n, gw_n, sleep, order_sel;
    logic [3:0]  bsel_n;
    logic [5:0]  addr;
    logic [35:0] wd;
    logic [35:0] rd;
    logic        drv;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fts_sram u_fts_sram (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_strobe_n (cpu_n),
        .ctl_strobe_n (ctl_n),
        .chip_sel_n   (sel_n),
        .adv_n        (adv_n),
        .addr         (addr),
        .order_sel    (order_sel),
        .oe_n         (oe_n),
        .bwe_n        (bwe_n),
        .byte_sel_n   (bsel_n),
        .all_wr_n     (gw_n),
        .sleep        (sleep),
        .wr_data      (wd),
        .rd_data      (rd),
        .rd_drive     (drv)
    );

    task automatic chk(input string req, input logic exp_oe, input logic [35:0] exp_d);
        checks++;
        if (drv !== exp_oe || rd !== exp_d) begin
            errors++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                     req, drv, rd, exp_oe, exp_d);
        end
    endtask

    task automatic step(input logic c_n, input logic k_n, input logic s_n, input logic a_n,
                        input logic g_n, input logic b_n, input logic [3:0] bs,
                        input logic [5:0] a, input logic [35:0] d, input logic sl);
        @(negedge clk);
        cpu_n = c_n; ctl_n = k_n; sel_n = s_n; adv_n = a_n;
        gw_n = g_n; bwe_n = b_n; bsel_n = bs; addr = a; wd = d; sleep = sl;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [35:0] merge(input logic [35:0] nw, input logic [35:0] old,
                                          input logic [3:0] sel_n_v);
        logic [35:0] r;
        for (int g = 0; g < 4; g++)
            r[g*9 +: 9] = sel_n_v[g] ? old[g*9 +: 9] : nw[g*9 +: 9];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: drive=%b data=%h expected completion", drv, rd);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [35:0] m;
        rst_n = 1'b0; cpu_n = 1'b1; ctl_n = 1'b1; sel_n = 1'b1; adv_n = 1'b1;
        oe_n = 1'b0; bwe_n = 1'b1; gw_n = 1'b1; sleep = 1'b0; order_sel = 1'b0;
        bsel_n = 4'hF; addr = '0; wd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R14 reset floats", 1'b0, 36'h0);

        for (int i = 0; i < NV; i++) begin
            step(VT[i].cpu_n, VT[i].ctl_n, VT[i].sel_n, VT[i].adv_n, VT[i].gw_n,
                 1'b1, 4'hF, VT[i].a, VT[i].wd, 1'b0);
            chk(vec_tag(i), VT[i].eoe, VT[i].ed);
        end

        // R6: output enable high floats the bus
        step(1, 0, 0, 1, 1, 1, 4'hF, 6'h10, 36'h0, 0);
        chk("R6 read before oe test", 1'b1, D0);
        @(negedge clk); oe_n = 1'b1;
        #1 chk("R6 oe high floats", 1'b0, 36'h0);
        @(negedge clk); oe_n = 1'b0;

        // R3: lane writes to lanes 0 and 2, including parity bits
        m = merge(DA, D0, 4'b1010);
        step(1, 0, 0, 1, 1, 0, 4'b1010, 6'h10, DA, 0);
        chk("R7 lane write floats", 1'b0, 36'h0);
        step(1, 0, 0, 1, 1, 1, 4'hF, 6'h10, 36'h0, 0);
        chk("R3 lane merge with parity", 1'b1, m);
        step(1, 0, 0, 1, 1, 1, 4'h0, 6'h10, 36'h0, 0);
        chk("R3 selects without lane enable ignored", 1'b1, m);

        // R11: interleaved order from start 1
        order_sel = 1'b1;
        step(1, 0, 0, 1, 1, 1, 4'hF, 6'h11, 36'h0, 0);
        chk("R11 start beat", 1'b1, D1);
        step(1, 1, 0, 0, 1, 1, 4'hF, 6'h00, 36'h0, 0);
        chk("R11 beat 1 xor", 1'b1, m);
        step(1, 1, 0, 0, 1, 1, 4'hF, 6'h00, 36'h0, 0);
        chk("R11 beat 2 xor", 1'b1, D3);
        step(1, 1, 0, 0, 1, 1, 4'hF, 6'h00, 36'h0, 0);
        chk("R11 beat 3 xor", 1'b1, D2);
        step(1, 1, 0, 0, 1, 1, 4'hF, 6'h00, 36'h0, 0);
        chk("R11 R12 wrap interleaved", 1'b1, D1);

        // R13: sleep floats at once, blocks a write, then resumes
        @(negedge clk); sleep = 1'b1;
        #1 chk("R13 async float", 1'b0, 36'h0);
        step(1, 0, 0, 1, 0, 1, 4'hF, 6'h12, DX, 1);
        chk("R13 sleeping floats", 1'b0, 36'h0);
        step(1, 0, 0, 1, 1, 1, 4'hF, 6'h12, 36'h0, 0);
        chk("R13 R8 first cycle after sleep", 1'b0, 36'h0);
        step(1, 1, 0, 1, 1, 1, 4'hF, 6'h00, 36'h0, 0);
        chk("R13 data kept, write ignored", 1'b1, D2);

        // R4: global write overrides lane controls
        step(1, 0, 0, 1, 0, 1, 4'hF, 6'h13, D5, 0);
        chk("R4 R7 global write floats", 1'b0, 36'h0);
        step(1, 0, 0, 1, 1, 1, 4'hF, 6'h13, 36'h0, 0);
        chk("R4 global write all lanes", 1'b1, D5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule